// File: doc/BRIEF.md
# Interrupt-to-DMA Start Vector Router

This block sits next to an interrupt controller and decides, for the interrupt that currently wins arbitration, whether the CPU services it or a DMA channel does. It holds one start-vector register per DMA channel. Each register names the interrupt vector that should start that channel. When the winning vector matches a programmed register, the CPU request is held off in the same cycle. A start request is then raised on the matching DMA channel and held until the DMA engine acknowledges it.

After an acknowledge, or when a DMA channel signals that its burst has ended, the router asks the interrupt controller to drop the source's request flag. It does this with a one-cycle clear pulse that carries the source vector. Clears that arrive together are queued and issued one per cycle, lowest DMA channel first. A channel cannot be re-requested while its request or its clear is still in flight. This keeps a flag that has not yet been dropped from starting a second transfer. The router assumes the interrupt controller drops the flag at the clock edge that ends the clear pulse.

Top module: `dma_vec_router`

## Requirements
- R1: After a synchronous active-low reset, all start-vector registers read as zero, `dma_req` is all zero, `cpu_suppress` is low and `clr_valid` is low.
- R2: A cycle with `cfg_we` high loads `cfg_data` into the start-vector register selected by `cfg_sel` (channel index 0..NCH-1). The new value takes part in matching from the next cycle on.
- R3: A start-vector register that holds zero matches no vector. A winning vector of zero never causes suppression or a DMA request.
- R4: `cpu_suppress` is high in exactly those cycles where `win_valid` is high and `win_vec` equals a nonzero start-vector register. It responds combinationally in the same cycle.
- R5: When several registers match, only the lowest-numbered DMA channel is requested. Its `dma_req` bit rises at the clock edge that ends the matching cycle.
- R6: A `dma_req` bit stays high until a cycle in which the matching `dma_ack` bit is high. It falls at that cycle's closing edge. An acknowledge on a channel with no request is ignored.
- R7: An acknowledge on a requesting channel leads to `clr_valid` being high for one cycle, starting at the second edge after the acknowledge cycle. `clr_vec` during that cycle carries the vector latched when the request was raised.
- R8: A `burst_end` strobe on a channel whose register is nonzero produces the same kind of one-cycle clear pulse, carrying that channel's current start vector.
- R9: Clears raised in the same cycle are issued one per cycle in ascending DMA channel order, with no clear lost.
- R10: A channel is not requested again while its request is outstanding, while its clear is queued, or during the cycle its clear pulse is out. The earliest new request comes at the edge after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Start-vector register write enable |
| cfg_sel | input | IW | DMA channel whose register is written |
| cfg_data | input | VW | Vector value to write |
| win_valid | input | 1 | A pending interrupt has won arbitration |
| win_vec | input | VW | Vector of the winning interrupt |
| dma_ack | input | NCH | Per-channel acknowledge from the DMA engine |
| burst_end | input | NCH | Per-channel burst-termination strobe |
| dma_req | output | NCH | Per-channel DMA start request |
| cpu_suppress | output | 1 | Holds off the CPU request for the winning interrupt |
| clr_valid | output | 1 | One-cycle request to drop a source flag |
| clr_vec | output | VW | Vector of the source whose flag is dropped |

## Verification
The bench builds the router with its defaults: eight channels and 8-bit vectors. Start vectors and winning vectors are drawn from the range 0..7, so zero registers, several registers holding the same vector, and rewrites of a register while its request is outstanding all occur often. With eight channels, an acknowledge or burst end on every channel in one cycle fills the clear queue to its full depth. The bench can therefore check the ascending drain order of R9 and the re-request lockout of R10 under contention.

// File: rtl/dvr_pkg.sv
// Package dvr_pkg
// Shared default sizes for the start-vector router. The widths themselves are
// parameters of each module; these constants only give them one common default.
package dvr_pkg;
    localparam int DVR_NCH_DEF = 8;   // DMA channels (one start-vector register each)
    localparam int DVR_VW_DEF  = 8;   // interrupt vector width
endpackage

// File: rtl/dvr_low_pick.sv
// Module dvr_low_pick
// Finds the lowest set bit of a request vector and reports its index.
// Assumes IW is wide enough to hold N-1. The result is purely combinational.
module dvr_low_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  bits,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top down so that the lowest set bit is written last
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dvr_vec_bank.sv
// Module dvr_vec_bank
// Holds one start-vector register per DMA channel and compares each register
// with the winning interrupt vector. A zero register stands for an unused
// channel and never matches. A select value outside the channel range is ignored.
module dvr_vec_bank #(
    parameter int NCH = 8,
    parameter int VW  = 8,
    parameter int IW  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [IW-1:0]           cfg_sel,
    input  logic [VW-1:0]           cfg_data,
    input  logic                    win_valid,
    input  logic [VW-1:0]           win_vec,
    output logic [NCH-1:0][VW-1:0]  start_vec,
    output logic [NCH-1:0]          hit
);
    for (genvar g = 0; g < NCH; g++) begin : g_reg
        // Per-channel register load from the write port
        always_ff @(posedge clk) begin
            if (!rst_n)
                start_vec[g] <= '0;
            else if (cfg_we && cfg_sel == IW'(g))
                start_vec[g] <= cfg_data;
        end

        // Match of this channel's programmed vector against the winner
        always_comb hit[g] = win_valid && (start_vec[g] != '0) && (start_vec[g] == win_vec);
    end
endmodule

// File: rtl/dvr_clr_arb.sv
// Module dvr_clr_arb
// Queues flag-clear requests, one pending bit and one vector per channel, and
// issues them one per cycle as a registered pulse, lowest channel first.
// A new request on a channel overwrites that channel's queued vector.
module dvr_clr_arb #(
    parameter int NCH = 8,
    parameter int VW  = 8,
    parameter int IW  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          set,
    input  logic [NCH-1:0][VW-1:0]  set_vec,
    output logic [NCH-1:0]          pend,
    output logic                    clr_valid,
    output logic [VW-1:0]           clr_vec,
    output logic [IW-1:0]           clr_ch
);
    logic [NCH-1:0][VW-1:0] pvec_q;
    logic [NCH-1:0]         served;
    logic                   p_any;
    logic [IW-1:0]          p_idx;

    dvr_low_pick #(.N(NCH), .IW(IW)) u_pick (
        .bits (pend),
        .any  (p_any),
        .idx  (p_idx)
    );

    // One-hot mask of the entry that is issued this cycle
    always_comb served = p_any ? ({{(NCH-1){1'b0}}, 1'b1} << p_idx) : '0;

    // Pending bits: drop the issued entry and add new requests
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= '0;
        else
            pend <= (pend & ~served) | set;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_vec
        // Capture the vector to report for each newly queued clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                pvec_q[g] <= '0;
            else if (set[g])
                pvec_q[g] <= set_vec[g];
        end
    end

    // Registered one-cycle clear pulse with its vector and channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_valid <= 1'b0;
            clr_vec   <= '0;
            clr_ch    <= '0;
        end else begin
            clr_valid <= p_any;
            if (p_any) begin
                clr_vec <= pvec_q[p_idx];
                clr_ch  <= p_idx;
            end
        end
    end
endmodule

// File: rtl/dma_vec_router.sv
// Module dma_vec_router
// Routes the winning interrupt either to the CPU or to a DMA channel, based on
// per-channel start-vector registers. On a match it holds off the CPU request
// combinationally and raises a start request on the lowest matching channel.
// The request is held until acknowledged. Acknowledges and burst ends become
// queued one-cycle flag-clear pulses. Assumes the interrupt controller drops
// the named flag at the edge that ends the clear pulse.
module dma_vec_router #(
    parameter int NCH = dvr_pkg::DVR_NCH_DEF,
    parameter int VW  = dvr_pkg::DVR_VW_DEF,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [IW-1:0]   cfg_sel,
    input  logic [VW-1:0]   cfg_data,
    input  logic            win_valid,
    input  logic [VW-1:0]   win_vec,
    input  logic [NCH-1:0]  dma_ack,
    input  logic [NCH-1:0]  burst_end,
    output logic [NCH-1:0]  dma_req,
    output logic            cpu_suppress,
    output logic            clr_valid,
    output logic [VW-1:0]   clr_vec
);
    logic [NCH-1:0][VW-1:0] start_vec;
    logic [NCH-1:0][VW-1:0] req_vec_q;
    logic [NCH-1:0][VW-1:0] clr_src_vec;
    logic [NCH-1:0]         hit;
    logic [NCH-1:0]         pend;
    logic [NCH-1:0]         busy;
    logic [NCH-1:0]         clr_set;
    logic                   hit_any;
    logic [IW-1:0]          hit_idx;
    logic [IW-1:0]          clr_ch;

    dvr_vec_bank #(.NCH(NCH), .VW(VW), .IW(IW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_data  (cfg_data),
        .win_valid (win_valid),
        .win_vec   (win_vec),
        .start_vec (start_vec),
        .hit       (hit)
    );

    dvr_low_pick #(.N(NCH), .IW(IW)) u_hit_pick (
        .bits (hit),
        .any  (hit_any),
        .idx  (hit_idx)
    );

    dvr_clr_arb #(.NCH(NCH), .VW(VW), .IW(IW)) u_clr (
        .clk       (clk),
        .rst_n     (rst_n),
        .set       (clr_set),
        .set_vec   (clr_src_vec),
        .pend      (pend),
        .clr_valid (clr_valid),
        .clr_vec   (clr_vec),
        .clr_ch    (clr_ch)
    );

    // Hold off the CPU whenever any DMA channel claims the winner
    always_comb cpu_suppress = hit_any;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Channel locked while its request or its clear is still in flight
        always_comb busy[g] = dma_req[g] || pend[g] || (clr_valid && clr_ch == IW'(g));

        // Clear sources: accepted request, or burst end on a programmed channel
        always_comb begin
            clr_set[g]     = (dma_req[g] && dma_ack[g]) || (burst_end[g] && start_vec[g] != '0);
            clr_src_vec[g] = (dma_req[g] && dma_ack[g]) ? req_vec_q[g] : start_vec[g];
        end

        // Start request: set on a winning match, held until acknowledged
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dma_req[g]   <= 1'b0;
                req_vec_q[g] <= '0;
            end else if (dma_req[g] && dma_ack[g]) begin
                dma_req[g]   <= 1'b0;
            end else if (hit_any && hit_idx == IW'(g) && !busy[g]) begin
                dma_req[g]   <= 1'b1;
                req_vec_q[g] <= start_vec[g];
            end
        end
    end
endmodule

// File: rtl/dma_vec_router_chk.sv
// Module dma_vec_router_chk
// Port-level properties of the start-vector router, attached by bind below.
// Only observes the block and drives nothing.
module dma_vec_router_chk #(
    parameter int NCH = 8,
    parameter int VW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           win_valid,
    input logic [VW-1:0]  win_vec,
    input logic [NCH-1:0] dma_ack,
    input logic [NCH-1:0] dma_req,
    input logic           cpu_suppress,
    input logic           clr_valid,
    input logic [VW-1:0]  clr_vec
);
    // R4: no suppression without a valid winner
    a_r4_idle_no_suppress: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |-> !cpu_suppress);

    // R3: a zero vector is never routed
    a_r3_zero_never_routes: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vec == '0) |-> !cpu_suppress);

    // R5: at most one channel newly requested per cycle
    a_r5_one_new_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dma_req & ~$past(dma_req)));

    // R6: an unacknowledged request stays high
    a_r6_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((dma_req & ~dma_ack) != '0) |=> ((dma_req & $past(dma_req & ~dma_ack)) == $past(dma_req & ~dma_ack)));

    // R6: an acknowledged request falls at the next edge
    a_r6_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ((dma_req & dma_ack) != '0) |=> ((dma_req & $past(dma_req & dma_ack)) == '0));

    // R7: a clear pulse always names a real source
    a_r7_clr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |-> (clr_vec != '0));
endmodule

bind dma_vec_router dma_vec_router_chk #(.NCH(NCH), .VW(VW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .win_valid    (win_valid),
    .win_vec      (win_vec),
    .dma_ack      (dma_ack),
    .dma_req      (dma_req),
    .cpu_suppress (cpu_suppress),
    .clr_valid    (clr_valid),
    .clr_vec      (clr_vec)
);

// File: tb/dma_vec_router_bench.sv
`timescale 1ns/1ps
module dma_vec_router_bench;
    localparam int NCH = 8;
    localparam int VW  = 8;
    localparam int IW  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [IW-1:0]  cfg_sel = '0;
    logic [VW-1:0]  cfg_data = '0;
    logic           win_valid = 1'b0;
    logic [VW-1:0]  win_vec = '0;
    logic [NCH-1:0] dma_ack = '0;
    logic [NCH-1:0] burst_end = '0;
    logic [NCH-1:0] dma_req;
    logic           cpu_suppress;
    logic           clr_valid;
    logic [VW-1:0]  clr_vec;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string phase = "R1 reset";

    always #2 clk = ~clk;   // 250 MHz

    dma_vec_router u_dma_vec_router (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .win_valid(win_valid), .win_vec(win_vec), .dma_ack(dma_ack), .burst_end(burst_end),
        .dma_req(dma_req), .cpu_suppress(cpu_suppress), .clr_valid(clr_valid), .clr_vec(clr_vec)
    );

    // Reference state, built from the requirements
    logic [VW-1:0]  m_sv [NCH];
    logic [VW-1:0]  m_rv [NCH];
    logic [VW-1:0]  m_pv [NCH];
    logic [NCH-1:0] m_req, m_pend;
    logic           m_cv;
    logic [VW-1:0]  m_cvec;
    int             m_cch;

    function automatic logic [NCH-1:0] exp_hit();
        logic [NCH-1:0] h = '0;
        for (int i = 0; i < NCH; i++)
            h[i] = win_valid && m_sv[i] != '0 && m_sv[i] == win_vec;
        return h;
    endfunction

    function automatic int lowest(logic [NCH-1:0] b);
        for (int i = 0; i < NCH; i++) if (b[i]) return i;
        return -1;
    endfunction

    // Reference update at each edge: R2, R5, R6, R7, R8, R9, R10
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin m_sv[i] = '0; m_rv[i] = '0; m_pv[i] = '0; end
            m_req = '0; m_pend = '0; m_cv = 1'b0; m_cvec = '0; m_cch = 0;
        end else begin
            logic [NCH-1:0] h, busy, set, n_req, n_pend;
            logic [VW-1:0]  setv [NCH];
            int w, p;
            h = exp_hit();
            w = lowest(h);
            p = lowest(m_pend);
            busy = m_req | m_pend;
            if (m_cv) busy[m_cch] = 1'b1;
            n_req = m_req;
            for (int i = 0; i < NCH; i++) begin
                set[i]  = (m_req[i] && dma_ack[i]) || (burst_end[i] && m_sv[i] != '0);
                setv[i] = (m_req[i] && dma_ack[i]) ? m_rv[i] : m_sv[i];
                if (m_req[i] && dma_ack[i]) n_req[i] = 1'b0;
                else if (w == i && !busy[i]) begin n_req[i] = 1'b1; m_rv[i] = m_sv[i]; end
            end
            n_pend = m_pend;
            m_cv = (p >= 0);
            if (p >= 0) begin m_cvec = m_pv[p]; m_cch = p; n_pend[p] = 1'b0; end
            n_pend = n_pend | set;
            for (int i = 0; i < NCH; i++) if (set[i]) m_pv[i] = setv[i];
            m_req = n_req;
            m_pend = n_pend;
            if (cfg_we && int'(cfg_sel) < NCH) m_sv[cfg_sel] = cfg_data;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare all outputs against the reference in the current cycle
    task automatic check_all();
        chk({phase, " dma_req"}, 32'(dma_req), 32'(m_req));
        chk({phase, " R4 cpu_suppress"}, 32'(cpu_suppress), 32'(|exp_hit()));
        chk({phase, " clr_valid"}, 32'(clr_valid), 32'(m_cv));
        if (m_cv) chk({phase, " clr_vec"}, 32'(clr_vec), 32'(m_cvec));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic wr(int sel, int data);
        cfg_we = 1'b1; cfg_sel = IW'(sel); cfg_data = VW'(data);
        tick();
        cfg_we = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) tick();
        chk("R1 reset dma_req", 32'(dma_req), 0);
        chk("R1 reset clr_valid", 32'(clr_valid), 0);
        rst_n = 1'b1;
        win_valid = 1'b1; win_vec = 8'd5;
        tick();
        chk("R1 no register programmed", 32'(cpu_suppress), 0);

        phase = "R2 write";
        win_valid = 1'b0;
        wr(2, 5);
        win_valid = 1'b1;
        #0.1;
        chk("R2 suppress after write", 32'(cpu_suppress), 1);
        tick();
        chk("R2 request on ch2", 32'(dma_req), 32'h04);

        phase = "R6 hold";
        repeat (4) tick();
        chk("R6 still requested", 32'(dma_req), 32'h04);
        dma_ack = 8'h01;            // ack on idle channel is ignored
        tick();
        chk("R6 idle ack ignored", 32'(dma_req), 32'h04);

        phase = "R10 lockout";
        dma_ack = 8'h04;
        tick();                     // ack edge
        dma_ack = '0;
        chk("R6 req dropped", 32'(dma_req), 0);
        chk("R7 not yet pulsed", 32'(clr_valid), 0);
        tick();
        chk("R7 pulse", 32'(clr_valid), 1);
        chk("R7 pulse vector", 32'(clr_vec), 5);
        chk("R10 no re-request during pulse", 32'(dma_req), 0);
        tick();
        chk("R7 single cycle", 32'(clr_valid), 0);
        chk("R10 no re-request at pulse end", 32'(dma_req), 0);
        tick();
        chk("R10 re-request after lockout", 32'(dma_req), 32'h04);
        win_valid = 1'b0;
        dma_ack = 8'h04; tick(); dma_ack = '0;
        repeat (3) tick();

        phase = "R3 zero";
        wr(3, 7); wr(3, 0);
        win_valid = 1'b1; win_vec = 8'd7;
        tick();
        chk("R3 cleared register no match", 32'(cpu_suppress), 0);
        win_vec = 8'd0;
        tick();
        chk("R3 zero vector no match", 32'(cpu_suppress), 0);

        phase = "R5 lowest";
        win_valid = 1'b0;
        wr(6, 9); wr(1, 9);
        win_valid = 1'b1; win_vec = 8'd9;
        tick();
        chk("R5 only ch1", 32'(dma_req), 32'h02);

        phase = "R9 drain";
        win_valid = 1'b0;
        wr(4, 8'h21);
        win_valid = 1'b1; win_vec = 8'h21;
        tick();
        win_valid = 1'b0;
        chk("R9 ch4 requested", 32'(dma_req), 32'h12);
        dma_ack = 8'h12; tick(); dma_ack = '0;
        tick();
        chk("R9 first ch1", 32'(clr_vec), 9);
        tick();
        chk("R9 second ch4", 32'(clr_vec), 32'h21);
        chk("R9 second valid", 32'(clr_valid), 1);
        tick();

        phase = "R8 burst";
        burst_end = 8'h48;          // ch3 zero: ignored; ch6 holds 9
        tick(); burst_end = '0;
        tick();
        chk("R8 burst pulse", 32'(clr_vec), 9);
        tick();
        chk("R8 zero channel ignored", 32'(clr_valid), 0);

        phase = "R2/R4/R5/R6/R7/R8/R9/R10 random";
        for (int n = 0; n < 4000; n++) begin
            cfg_we = ($urandom_range(0, 9) == 0);
            cfg_sel = IW'($urandom_range(0, NCH - 1));
            cfg_data = VW'($urandom_range(0, 7));
            win_valid = ($urandom_range(0, 3) != 0);
            win_vec = VW'($urandom_range(0, 7));
            for (int i = 0; i < NCH; i++) begin
                dma_ack[i] = ($urandom_range(0, 9) < 3);
                burst_end[i] = ($urandom_range(0, 19) == 0);
            end
            if (n % 500 == 7) begin dma_ack = '1; burst_end = '1; end
            tick();
        end
        cfg_we = 1'b0; dma_ack = '0; burst_end = '0; win_valid = 1'b0;
        repeat (12) tick();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule